// File: doc/BRIEF.md
# Burst Transfer Address Sequencer

This block sits between the cache/request side of a bus master with a 64-bit data path and the bus termination logic. It takes one transaction request at a time and works out whether the bus sees a single data beat or a four-beat burst that moves a whole 32-byte line. It then presents the address of each beat. Before it accepts the next request, it waits for the termination logic to acknowledge every beat.

A burst is used only for cacheable traffic, and a store may burst only when it is also marked write-back. The starting double-word of a burst depends on the request kind. A cache-miss fill starts at the double-word that holds the critical data, so that data comes back first. A line write-back starts at the beginning of the line. Any other burst read starts at the double-word that holds the address. Later beats step through the line one double-word at a time and wrap around within it. A single beat carries the request address and byte count through unchanged, and it may be misaligned.

Top module: `burst_addr_seq`

## Requirements
- R1: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high exactly when no transfer is active. A request held while a transfer is active changes neither that transfer's beat addresses nor its indications.
- R2: The transfer is a burst (`burst_out` high while `xfer_active`) if and only if `req_cacheable` is 1 and either `req_store` is 0 or `req_writeback` is 1. Every other request becomes a single beat.
- R3: A single beat presents `req_addr` unchanged on `beat_addr`, including misaligned addresses, and presents `req_bytes` (1 to 8) on `xfer_bytes`. One `beat_ack` ends the transfer.
- R4: For `req_kind` 0 (cache-miss fill) and 2 (other), the first burst beat address is `req_addr` with bits [2:0] cleared.
- R5: For `req_kind` 1 (line write-back), the first burst beat address is `req_addr` with bits [4:0] cleared.
- R6: During a burst, `xfer_bytes` reads 8. Each acknowledged beat that is not the last adds 1 modulo 4 to `beat_addr[4:3]`. Bits [2:0] stay zero and the bits above bit 4 stay fixed, so the burst has exactly four beats.
- R7: While a transfer is active and `beat_ack` is low, `beat_addr` keeps its value.
- R8: The cycle after the final beat's `beat_ack` is taken, `xfer_active` is low and `done` is high, and `done` is high for that one cycle only.
- R9: After reset, `xfer_active`, `burst_out` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 32 | Request byte address |
| req_bytes | input | 4 | Byte count for a single beat (1 to 8) |
| req_cacheable | input | 1 | Request is cacheable |
| req_writeback | input | 1 | Store target is write-back |
| req_store | input | 1 | Request is a store |
| req_kind | input | 2 | 0 fill, 1 line write-back, 2 other |
| beat_ack | input | 1 | Current beat accepted by termination logic |
| xfer_active | output | 1 | Transfer in progress |
| burst_out | output | 1 | Current transfer is a four-beat burst |
| beat_addr | output | 32 | Address of the current beat |
| xfer_bytes | output | 4 | Bytes per beat for the current transfer |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
A wrong beat index or start offset shows up at once: the first `beat_addr` after acceptance, or the one after the next acknowledged beat, lands on the wrong double-word. A corrupted transfer-type register shows in `burst_out` and `xfer_bytes` in the cycle after the request is taken. A last-beat decision that comes too early or too late shows as `done` and the fall of `xfer_active` arriving one acknowledgement off from four (or one). A stuck activity flag shows as `req_ready` staying low. The bench stalls acknowledgements and offers requests while busy, so that hold and ignore faults become visible before the next beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    KIND_FILL   = 2'd0,
    KIND_LINEWR = 2'd1,
    KIND_OTHER  = 2'd2,
    KIND_RSVD   = 2'd3
  } req_kind_e;

endpackage

// File: rtl/burst_seq_decide.sv
module burst_seq_decide
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 3,
  parameter int LINE_W  = 5,
  parameter int BYTES_W = OFS_W + 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTES_W-1:0] nbytes_in,
  input  logic               cacheable,
  input  logic               writeback,
  input  logic               store,
  input  logic [1:0]         kind,
  output logic               is_burst,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [BYTES_W-1:0] nbytes_out
);

  localparam logic [ADDR_W-1:0] DW_MASK   = ADDR_W'((64'd1 << OFS_W) - 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((64'd1 << LINE_W) - 1);
  localparam logic [BYTES_W-1:0] DW_BYTES = BYTES_W'(64'd1 << OFS_W);

  req_kind_e kind_e;

  always_comb begin
    kind_e   = req_kind_e'(kind);
    is_burst = cacheable && (!store || writeback);
    if (!is_burst) begin
      start_addr = addr;
      nbytes_out = nbytes_in;
    end else if (kind_e == KIND_LINEWR) begin
      start_addr = addr & ~LINE_MASK;
      nbytes_out = DW_BYTES;
    end else begin
      start_addr = addr & ~DW_MASK;
      nbytes_out = DW_BYTES;
    end
  end

endmodule

// File: rtl/burst_seq_beat_ctr.sv
module burst_seq_beat_ctr #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 3,
  parameter int LINE_W = 5,
  parameter int IDX_W  = LINE_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              burst_in,
  input  logic              adv,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              last
);

  localparam logic [IDX_W-1:0] IDX_LAST = '1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic              burst_q, burst_d;

  always_comb begin
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    burst_d = burst_q;
    if (load) begin
      addr_d  = start_addr;
      cnt_d   = '0;
      burst_d = burst_in;
    end else if (adv && !last) begin
      addr_d[LINE_W-1:OFS_W] = addr_q[LINE_W-1:OFS_W] + IDX_W'(1);
      cnt_d = cnt_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      burst_q <= 1'b0;
    end else if (load || adv) begin
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      burst_q <= burst_d;
    end
  end

  assign beat_addr = addr_q;
  assign last      = !burst_q || (cnt_q == IDX_LAST);

  assert_wrap_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && burst_q && !last) |=>
      (beat_addr[LINE_W-1:OFS_W] == $past(beat_addr[LINE_W-1:OFS_W]) + IDX_W'(1)));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (beat_addr[ADDR_W-1:LINE_W] == $past(beat_addr[ADDR_W-1:LINE_W])));

  assert_hold_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(beat_addr));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DW_BYTES   = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  input  logic              req_cacheable,
  input  logic              req_writeback,
  input  logic              req_store,
  input  logic [1:0]        req_kind,
  input  logic              beat_ack,
  output logic              xfer_active,
  output logic              burst_out,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [3:0]        xfer_bytes,
  output logic              done
);

  localparam int OFS_W   = $clog2(DW_BYTES);
  localparam int LINE_W  = $clog2(LINE_BYTES);
  localparam int BYTES_W = 4;

  logic              active_q, active_d;
  logic              burst_q, burst_d;
  logic              done_q, done_d;
  logic [3:0]        bytes_q, bytes_d;
  logic              accept, fin, last;
  logic              dec_burst;
  logic [ADDR_W-1:0] dec_start;
  logic [3:0]        dec_bytes;

  burst_seq_decide #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_W(LINE_W), .BYTES_W(BYTES_W)
  ) u_decide (
    .addr       (req_addr),
    .nbytes_in  (req_bytes),
    .cacheable  (req_cacheable),
    .writeback  (req_writeback),
    .store      (req_store),
    .kind       (req_kind),
    .is_burst   (dec_burst),
    .start_addr (dec_start),
    .nbytes_out (dec_bytes)
  );

  burst_seq_beat_ctr #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_W(LINE_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .start_addr (dec_start),
    .burst_in   (dec_burst),
    .adv        (active_q && beat_ack),
    .beat_addr  (beat_addr),
    .last       (last)
  );

  assign req_ready = !active_q;
  assign accept    = req_valid && !active_q;
  assign fin       = active_q && beat_ack && last;

  always_comb begin
    active_d = active_q;
    burst_d  = burst_q;
    bytes_d  = bytes_q;
    done_d   = fin;
    if (accept) begin
      active_d = 1'b1;
      burst_d  = dec_burst;
      bytes_d  = dec_bytes;
    end else if (fin) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      burst_q  <= 1'b0;
      bytes_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      if (accept) begin
        burst_q <= burst_d;
        bytes_q <= bytes_d;
      end
    end
  end

  assign xfer_active = active_q;
  assign burst_out   = active_q && burst_q;
  assign xfer_bytes  = bytes_q;
  assign done        = done_q;

  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (xfer_active && !done));

  assert_busy_keeps_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !fin) |=> ($stable(burst_out) && $stable(xfer_bytes)));

  assert_finish_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done && !xfer_active));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_burst_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_out |-> (xfer_bytes == 4'(DW_BYTES)));

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [3:0]  req_bytes;
  logic        req_cacheable, req_writeback, req_store;
  logic [1:0]  req_kind;
  logic        beat_ack;
  logic        xfer_active, burst_out, done;
  logic [31:0] beat_addr;
  logic [3:0]  xfer_bytes;

  int errs   = 0;
  int checks = 0;

  always #10 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes),
    .req_cacheable(req_cacheable), .req_writeback(req_writeback),
    .req_store(req_store), .req_kind(req_kind),
    .beat_ack(beat_ack),
    .xfer_active(xfer_active), .burst_out(burst_out),
    .beat_addr(beat_addr), .xfer_bytes(xfer_bytes), .done(done)
  );

  // vector table: address, bytes, {cacheable,writeback,store}, kind, expected burst, expected start
  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000_0018, 32'h2000_0013, 32'h3000_003C,
                                          32'h4000_000D, 32'h5000_0005, 32'h6000_0008,
                                          32'h7000_001F};
  localparam logic [3:0]  V_BYTES [NV] = '{4'd8, 4'd4, 4'd4, 4'd2, 4'd3, 4'd8, 4'd1};
  localparam logic [2:0]  V_FLAGS [NV] = '{3'b100, 3'b111, 3'b111, 3'b100, 3'b000, 3'b101, 3'b011};
  localparam logic [1:0]  V_KIND  [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 2'd1};
  localparam logic        V_BURST [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0] V_START [NV] = '{32'h1000_0018, 32'h2000_0010, 32'h3000_0020,
                                          32'h4000_0008, 32'h5000_0005, 32'h6000_0008,
                                          32'h7000_001F};

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] beat_exp(input logic [31:0] start, input int k);
    logic [1:0] w;
    w = start[4:3] + 2'(k);
    return {start[31:5], w, 3'b000};
  endfunction

  task automatic issue(input int i);
    @(negedge clk);
    req_valid     = 1'b1;
    req_addr      = V_ADDR[i];
    req_bytes     = V_BYTES[i];
    {req_cacheable, req_writeback, req_store} = V_FLAGS[i];
    req_kind      = V_KIND[i];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input int i, input string rq);
    int n;
    logic [31:0] e;
    issue(i);
    chk({rq, " active after accept"}, 32'(xfer_active), 32'd1);
    chk({rq, " R2 burst indication"}, 32'(burst_out), 32'(V_BURST[i]));
    chk({rq, " R3/R6 beat size"}, 32'(xfer_bytes), V_BURST[i] ? 32'd8 : 32'(V_BYTES[i]));
    n = V_BURST[i] ? 4 : 1;
    for (int k = 0; k < n; k++) begin
      e = V_BURST[i] ? beat_exp(V_START[i], k) : V_START[i];
      chk({rq, " R6 beat address"}, beat_addr, e);
      beat_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      beat_ack = 1'b0;
    end
    chk({rq, " R8 done pulse"}, 32'(done), 32'd1);
    chk({rq, " R8 idle after last beat"}, 32'(xfer_active), 32'd0);
    @(negedge clk);
    chk({rq, " R8 done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_bytes = '0;
    req_cacheable = 1'b0; req_writeback = 1'b0; req_store = 1'b0;
    req_kind = '0; beat_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R9 active at reset", 32'(xfer_active), 32'd0);
    chk("R9 ready at reset", 32'(req_ready), 32'd1);
    chk("R9 done at reset", 32'(done), 32'd0);
    chk("R9 burst at reset", 32'(burst_out), 32'd0);

    run_vec(0, "R4 fill critical");
    run_vec(1, "R4 fill store wb");
    run_vec(2, "R5 line write");
    run_vec(3, "R4 other read");
    run_vec(4, "R3 uncached single");
    run_vec(5, "R2 store no wb");
    run_vec(6, "R2 uncached store");

    // R7 stall plus R1 busy-time request
    issue(2);
    chk("R1 ready low while busy", 32'(req_ready), 32'd0);
    req_valid = 1'b1;
    req_addr  = 32'hABCD_0008;
    req_bytes = 4'd1;
    {req_cacheable, req_writeback, req_store} = 3'b000;
    req_kind  = 2'd2;
    repeat (3) begin
      @(negedge clk);
      chk("R7 address held without ack", beat_addr, 32'h3000_0020);
    end
    chk("R1 busy request kept burst", 32'(burst_out), 32'd1);
    for (int k = 0; k < 4; k++) begin
      chk("R1 beat address unaffected", beat_addr, beat_exp(32'h3000_0020, k));
      beat_ack = 1'b1;
      if (k == 3) req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      beat_ack = 1'b0;
      if (k < 3) begin
        @(negedge clk);
        chk("R7 hold between acks", beat_addr, beat_exp(32'h3000_0020, k + 1));
      end
    end
    chk("R8 done after stalled burst", 32'(done), 32'd1);
    @(negedge clk);
    chk("R1 no request taken after drop", 32'(xfer_active), 32'd0);

    // R6 wrap from last double-word of a line
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0FF9; req_bytes = 4'd8;
    {req_cacheable, req_writeback, req_store} = 3'b100; req_kind = 2'd0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R6 wrap sequence", beat_addr, beat_exp(32'h0000_0FF8, k));
      beat_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      beat_ack = 1'b0;
    end
    chk("R8 done after wrap", 32'(done), 32'd1);

    finish_run();
  end

endmodule